// File: doc/BRIEF.md
# Scaled Window Source Coordinate Stepper

This block turns the geometry of a scaled display window into a source-pixel coordinate for every output pixel. A configuration load captures the source width and height and the source start position, all in unsigned 20.12 fixed point, together with the integer output width and height and the pixel size in bytes. The block then derives a per-axis step by fixed-point division in a multi-cycle divider, limits each step to a ceiling set by the axis and the pixel size, and reports the start offsets and the source line length in bytes.

Once the steps are valid, a digital differential analyzer walks the source plane. A pixel-advance strobe moves the horizontal accumulator by one horizontal step. A line-start strobe returns the horizontal accumulator to its seed and moves the vertical accumulator by one vertical step. The outputs give, for each axis, the integer source index and the 12-bit fractional phase a filter would use, plus the byte offset of the current source pixel within its line. Pixel fetching, filtering and memory access belong to the surrounding logic.

Top module: `dda_src_stepper`

## Requirements
- R1: Each step equals floor(N * 4096 / D), where N is the source size minus 1.0 (0 if the size is below 1.0) and D is (out - 1) * 4096, or 4096 when the output size is 0 or 1; all values are unsigned 20.12 (value = raw / 4096).
- R2: The vertical step never exceeds 15.0 (raw 61440); a larger quotient is replaced by 61440.
- R3: The horizontal step ceiling is 8.0 (raw 32768) when cfg_bpp is 2 and 4.0 (raw 16384) when cfg_bpp is 4; any other cfg_bpp value is handled as 4 bytes and sets cfg_warn, which then stays high until reset.
- R4: step_valid is low from the cycle after cfg_load until the division finishes; while it is low, line_start and pix_adv have no effect on the coordinate outputs.
- R5: When step_valid rises, src_x_frac and src_y_frac equal the low 12 bits of the start positions and src_x_idx and src_y_idx equal their integer parts (bits 31:12).
- R6: After a load, x_byte_off equals the integer part of the horizontal start times the effective pixel size, y_line_off equals the integer part of the vertical start, and line_bytes equals the integer part of the source width times the effective pixel size.
- R7: Each pixel-advance strobe adds the horizontal step to the horizontal accumulator; after k strobes src_x_idx and src_x_frac are the integer and fraction of start_x_int*4096 + start_x_frac + k*h_step, and pix_byte_off equals src_x_idx times the effective pixel size; outputs update on the clock edge that samples the strobe.
- R8: A line-start strobe returns the horizontal coordinate to its seed (R5) and adds the vertical step to the vertical accumulator.
- R9: When line_start and pix_adv are high in the same cycle, the line start wins on the horizontal axis (the advance is dropped) and the vertical step is still applied.
- R10: After reset all outputs are zero, including step_valid and cfg_warn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture the configuration and start the step division |
| cfg_src_w | input | 32 | Source width, 20.12 |
| cfg_src_h | input | 32 | Source height, 20.12 |
| cfg_start_x | input | 32 | Horizontal source start, 20.12 |
| cfg_start_y | input | 32 | Vertical source start, 20.12 |
| cfg_out_w | input | 16 | Output width in pixels |
| cfg_out_h | input | 16 | Output height in lines |
| cfg_bpp | input | 3 | Bytes per pixel (2 or 4; others handled as 4) |
| line_start | input | 1 | Begin a new output line |
| pix_adv | input | 1 | Advance one output pixel |
| step_valid | output | 1 | Steps are computed and strobes are accepted |
| h_step | output | 32 | Horizontal step, 20.12 |
| v_step | output | 32 | Vertical step, 20.12 |
| cfg_warn | output | 1 | Sticky flag: unsupported pixel size was loaded |
| line_bytes | output | 22 | Source line length in bytes |
| x_byte_off | output | 22 | Byte offset of the horizontal start |
| y_line_off | output | 20 | Line offset of the vertical start |
| src_x_idx | output | 20 | Current horizontal source index |
| src_x_frac | output | 12 | Current horizontal phase |
| src_y_idx | output | 20 | Current vertical source index |
| src_y_frac | output | 12 | Current vertical phase |
| pix_byte_off | output | 22 | Byte offset of the current source pixel in its line |

## Verification
The two functions that can meet in one cycle are the line start and the pixel advance, which both want to write the horizontal accumulator. The bench raises both strobes in the same cycle after several advances within a line and judges the result against its own model: the horizontal coordinate must return to its seed, with no extra step, while the vertical coordinate moves by one step. It also fires strobes while a division is pending, where they must leave every coordinate output unchanged.

// File: rtl/dda_pkg.sv
package dda_pkg;
  localparam int FX_W   = 32;
  localparam int FRAC_W = 12;
  localparam int V_CEIL_INT    = 15;
  localparam int H_CEIL_2B_INT = 8;
  localparam int H_CEIL_4B_INT = 4;

  typedef enum logic [1:0] {
    AX_H = 2'd0,
    AX_V = 2'd1
  } axis_e;

  // shift amount applied for the effective pixel size
  function automatic logic [1:0] bpp_shift(input logic [2:0] bpp);
    return (bpp == 3'd2) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/dda_div.sv
module dda_div #(
  parameter int NUM_W  = 32,
  parameter int DEN_W  = 32,
  parameter int FRAC_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NUM_W-1:0]          num,
  input  logic [DEN_W-1:0]          den,
  output logic                      done,
  output logic [NUM_W+FRAC_W-1:0]   quo
);
  localparam int QW = NUM_W + FRAC_W;
  localparam int CW = $clog2(QW);

  logic [QW-1:0]    dvd;
  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt;
  logic             run;

  logic [DEN_W:0]   rem_sh;
  logic [DEN_W+1:0] diff;
  logic             ge;

  always_comb begin
    rem_sh = {rem[DEN_W-1:0], dvd[QW-1]};
    diff   = {1'b0, rem_sh} - {2'b00, den_q};
    ge     = ~diff[DEN_W+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd   <= {num, {FRAC_W{1'b0}}};
        rem   <= '0;
        den_q <= den;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        rem <= ge ? diff[DEN_W:0] : rem_sh;
        dvd <= {dvd[QW-2:0], ge};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(QW - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = dvd;

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> !run); // R1
endmodule

// File: rtl/dda_cfg.sv
module dda_cfg #(
  parameter int FX_W   = dda_pkg::FX_W,
  parameter int FRAC_W = dda_pkg::FRAC_W,
  parameter int OUT_W  = 16,
  parameter int BPP_W  = 3,
  localparam int INT_W = FX_W - FRAC_W,
  localparam int OFF_W = INT_W + 2,
  localparam int QW    = FX_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [FX_W-1:0]   src_w,
  input  logic [FX_W-1:0]   src_h,
  input  logic [FX_W-1:0]   start_x,
  input  logic [FX_W-1:0]   start_y,
  input  logic [OUT_W-1:0]  out_w,
  input  logic [OUT_W-1:0]  out_h,
  input  logic [BPP_W-1:0]  bpp,
  output logic              seed,
  output logic              step_valid,
  output logic [FX_W-1:0]   h_step,
  output logic [FX_W-1:0]   v_step,
  output logic [FRAC_W-1:0] h_init,
  output logic [FRAC_W-1:0] v_init,
  output logic [INT_W-1:0]  x_int0,
  output logic [INT_W-1:0]  y_int0,
  output logic [1:0]        pix_shift,
  output logic              warn,
  output logic [OFF_W-1:0]  line_bytes,
  output logic [OFF_W-1:0]  x_byte_off,
  output logic [INT_W-1:0]  y_line_off
);
  import dda_pkg::*;

  localparam logic [FX_W-1:0] ONE_FX = FX_W'(1) << FRAC_W;
  localparam logic [QW-1:0] V_CEIL  = QW'(V_CEIL_INT)    << FRAC_W;
  localparam logic [QW-1:0] H_CEIL2 = QW'(H_CEIL_2B_INT) << FRAC_W;
  localparam logic [QW-1:0] H_CEIL4 = QW'(H_CEIL_4B_INT) << FRAC_W;

  logic [FX_W-1:0]  num  [2];
  logic [FX_W-1:0]  den  [2];
  logic [QW-1:0]    quo  [2];
  logic [1:0]       done;
  logic             is2b;
  logic [1:0]       shift_in;
  logic [QW-1:0]    h_ceil;

  assign shift_in = bpp_shift(3'(bpp));

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_axis
      logic [FX_W-1:0]  src;
      logic [OUT_W-1:0] outn;
      assign src  = (g == int'(AX_H)) ? src_w : src_h;
      assign outn = (g == int'(AX_H)) ? out_w : out_h;
      always_comb begin
        num[g] = (src >= ONE_FX) ? (src - ONE_FX) : '0;
        den[g] = (outn > OUT_W'(1)) ? (FX_W'(outn - 1'b1) << FRAC_W) : ONE_FX;
      end
      dda_div #(.NUM_W(FX_W), .DEN_W(FX_W), .FRAC_W(FRAC_W)) div_i (
        .clk   (clk),
        .rst   (rst),
        .start (cfg_load),
        .num   (num[g]),
        .den   (den[g]),
        .done  (done[g]),
        .quo   (quo[g])
      );
    end
  endgenerate

  assign seed   = done[0];
  assign h_ceil = is2b ? H_CEIL2 : H_CEIL4;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_valid <= 1'b0;
      h_step     <= '0;
      v_step     <= '0;
      h_init     <= '0;
      v_init     <= '0;
      x_int0     <= '0;
      y_int0     <= '0;
      pix_shift  <= '0;
      is2b       <= 1'b0;
      warn       <= 1'b0;
      line_bytes <= '0;
      x_byte_off <= '0;
      y_line_off <= '0;
    end else if (cfg_load) begin
      step_valid <= 1'b0;
      h_init     <= start_x[FRAC_W-1:0];
      v_init     <= start_y[FRAC_W-1:0];
      x_int0     <= start_x[FX_W-1:FRAC_W];
      y_int0     <= start_y[FX_W-1:FRAC_W];
      pix_shift  <= shift_in;
      is2b       <= (bpp == BPP_W'(2));
      if (bpp != BPP_W'(2) && bpp != BPP_W'(4)) warn <= 1'b1;
      line_bytes <= OFF_W'(src_w[FX_W-1:FRAC_W]) << shift_in;
      x_byte_off <= OFF_W'(start_x[FX_W-1:FRAC_W]) << shift_in;
      y_line_off <= start_y[FX_W-1:FRAC_W];
    end else if (seed) begin
      step_valid <= 1'b1;
      h_step     <= (quo[0] > h_ceil) ? h_ceil[FX_W-1:0] : quo[0][FX_W-1:0];
      v_step     <= (quo[1] > V_CEIL) ? V_CEIL[FX_W-1:0] : quo[1][FX_W-1:0];
    end
  end

  AST_DIV_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    done[0] == done[1]); // R1
  AST_VSTEP_CEIL: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> (v_step <= V_CEIL[FX_W-1:0])); // R2
  AST_HSTEP_CEIL: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> (h_step <= H_CEIL2[FX_W-1:0])); // R3
  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (rst)
    warn |=> warn); // R3
  AST_LOAD_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> !step_valid); // R4
endmodule

// File: rtl/dda_walk.sv
module dda_walk #(
  parameter int FX_W   = dda_pkg::FX_W,
  parameter int FRAC_W = dda_pkg::FRAC_W,
  localparam int INT_W = FX_W - FRAC_W,
  localparam int OFF_W = INT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed,
  input  logic              step_valid,
  input  logic              line_start,
  input  logic              pix_adv,
  input  logic [FX_W-1:0]   h_step,
  input  logic [FX_W-1:0]   v_step,
  input  logic [FRAC_W-1:0] h_init,
  input  logic [FRAC_W-1:0] v_init,
  input  logic [INT_W-1:0]  x_int0,
  input  logic [INT_W-1:0]  y_int0,
  input  logic [1:0]        pix_shift,
  output logic [INT_W-1:0]  x_idx,
  output logic [FRAC_W-1:0] x_frac,
  output logic [INT_W-1:0]  y_idx,
  output logic [FRAC_W-1:0] y_frac,
  output logic [OFF_W-1:0]  pix_off
);
  logic [FX_W-1:0]  h_acc, v_acc, h_nxt, v_nxt;
  logic [INT_W-1:0] x_idx_nxt;

  always_comb begin
    h_nxt = h_acc;
    v_nxt = v_acc;
    if (seed) begin
      h_nxt = FX_W'(h_init);
      v_nxt = FX_W'(v_init);
    end else if (step_valid) begin
      if (line_start) begin
        h_nxt = FX_W'(h_init);
        v_nxt = v_acc + v_step;
      end else if (pix_adv) begin
        h_nxt = h_acc + h_step;
      end
    end
    x_idx_nxt = x_int0 + h_nxt[FX_W-1:FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_acc   <= '0;
      v_acc   <= '0;
      x_idx   <= '0;
      x_frac  <= '0;
      y_idx   <= '0;
      y_frac  <= '0;
      pix_off <= '0;
    end else begin
      h_acc   <= h_nxt;
      v_acc   <= v_nxt;
      x_idx   <= x_idx_nxt;
      x_frac  <= h_nxt[FRAC_W-1:0];
      y_idx   <= y_int0 + v_nxt[FX_W-1:FRAC_W];
      y_frac  <= v_nxt[FRAC_W-1:0];
      pix_off <= OFF_W'(x_idx_nxt) << pix_shift;
    end
  end

  AST_HOLD_WHILE_INVALID: assert property (@(posedge clk) disable iff (rst)
    (!step_valid && !seed) |=> ($stable(x_frac) && $stable(y_frac))); // R4
  AST_LINE_KEEPS_VFRAC_ON_ADV: assert property (@(posedge clk) disable iff (rst)
    (step_valid && pix_adv && !line_start && !seed) |=> $stable(y_frac)); // R7
endmodule

// File: rtl/dda_src_stepper.sv
module dda_src_stepper #(
  parameter int FX_W   = dda_pkg::FX_W,
  parameter int FRAC_W = dda_pkg::FRAC_W,
  parameter int OUT_W  = 16,
  parameter int BPP_W  = 3,
  localparam int INT_W = FX_W - FRAC_W,
  localparam int OFF_W = INT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [FX_W-1:0]   cfg_src_w,
  input  logic [FX_W-1:0]   cfg_src_h,
  input  logic [FX_W-1:0]   cfg_start_x,
  input  logic [FX_W-1:0]   cfg_start_y,
  input  logic [OUT_W-1:0]  cfg_out_w,
  input  logic [OUT_W-1:0]  cfg_out_h,
  input  logic [BPP_W-1:0]  cfg_bpp,
  input  logic              line_start,
  input  logic              pix_adv,
  output logic              step_valid,
  output logic [FX_W-1:0]   h_step,
  output logic [FX_W-1:0]   v_step,
  output logic              cfg_warn,
  output logic [OFF_W-1:0]  line_bytes,
  output logic [OFF_W-1:0]  x_byte_off,
  output logic [INT_W-1:0]  y_line_off,
  output logic [INT_W-1:0]  src_x_idx,
  output logic [FRAC_W-1:0] src_x_frac,
  output logic [INT_W-1:0]  src_y_idx,
  output logic [FRAC_W-1:0] src_y_frac,
  output logic [OFF_W-1:0]  pix_byte_off
);
  logic              seed;
  logic [FRAC_W-1:0] h_init, v_init;
  logic [INT_W-1:0]  x_int0, y_int0;
  logic [1:0]        pix_shift;

  dda_cfg #(.FX_W(FX_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .BPP_W(BPP_W)) cfg_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_load   (cfg_load),
    .src_w      (cfg_src_w),
    .src_h      (cfg_src_h),
    .start_x    (cfg_start_x),
    .start_y    (cfg_start_y),
    .out_w      (cfg_out_w),
    .out_h      (cfg_out_h),
    .bpp        (cfg_bpp),
    .seed       (seed),
    .step_valid (step_valid),
    .h_step     (h_step),
    .v_step     (v_step),
    .h_init     (h_init),
    .v_init     (v_init),
    .x_int0     (x_int0),
    .y_int0     (y_int0),
    .pix_shift  (pix_shift),
    .warn       (cfg_warn),
    .line_bytes (line_bytes),
    .x_byte_off (x_byte_off),
    .y_line_off (y_line_off)
  );

  dda_walk #(.FX_W(FX_W), .FRAC_W(FRAC_W)) walk_i (
    .clk        (clk),
    .rst        (rst),
    .seed       (seed),
    .step_valid (step_valid),
    .line_start (line_start),
    .pix_adv    (pix_adv),
    .h_step     (h_step),
    .v_step     (v_step),
    .h_init     (h_init),
    .v_init     (v_init),
    .x_int0     (x_int0),
    .y_int0     (y_int0),
    .pix_shift  (pix_shift),
    .x_idx      (src_x_idx),
    .x_frac     (src_x_frac),
    .y_idx      (src_y_idx),
    .y_frac     (src_y_frac),
    .pix_off    (pix_byte_off)
  );

  AST_SEED_RAISES_VALID: assert property (@(posedge clk) disable iff (rst)
    (seed && !cfg_load) |=> step_valid); // R5
endmodule

// File: tb/dda_src_stepper_tb_top.sv
module dda_src_stepper_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, cfg_load, line_start, pix_adv;
  logic [31:0] cfg_src_w, cfg_src_h, cfg_start_x, cfg_start_y;
  logic [15:0] cfg_out_w, cfg_out_h;
  logic [2:0]  cfg_bpp;
  logic        step_valid, cfg_warn;
  logic [31:0] h_step, v_step;
  logic [21:0] line_bytes, x_byte_off, pix_byte_off;
  logic [19:0] y_line_off, src_x_idx, src_y_idx;
  logic [11:0] src_x_frac, src_y_frac;

  dda_src_stepper dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_src_w(cfg_src_w), .cfg_src_h(cfg_src_h),
    .cfg_start_x(cfg_start_x), .cfg_start_y(cfg_start_y),
    .cfg_out_w(cfg_out_w), .cfg_out_h(cfg_out_h), .cfg_bpp(cfg_bpp),
    .line_start(line_start), .pix_adv(pix_adv),
    .step_valid(step_valid), .h_step(h_step), .v_step(v_step),
    .cfg_warn(cfg_warn), .line_bytes(line_bytes), .x_byte_off(x_byte_off),
    .y_line_off(y_line_off), .src_x_idx(src_x_idx), .src_x_frac(src_x_frac),
    .src_y_idx(src_y_idx), .src_y_frac(src_y_frac), .pix_byte_off(pix_byte_off)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  bit exp_warn = 0;
  longint e_hs, e_vs, e_bpp, h_acc, v_acc;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint step_of(input longint src, input longint outn,
                                     input longint ceil_v);
    longint num, den, q;
    num = (src >= 4096) ? src - 4096 : 0;
    den = (outn > 1) ? (outn - 1) * 4096 : 4096;
    q = (num * 4096) / den;
    return (q > ceil_v) ? ceil_v : q;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_pos(input string req);
    longint xi, yi;
    xi = ((cfg_start_x >> 12) + (h_acc >> 12)) & 20'hFFFFF;
    yi = ((cfg_start_y >> 12) + (v_acc >> 12)) & 20'hFFFFF;
    chk({req, " x_idx"}, src_x_idx, xi);
    chk({req, " x_frac"}, src_x_frac, h_acc & 12'hFFF);
    chk({req, " y_idx"}, src_y_idx, yi);
    chk({req, " y_frac"}, src_y_frac, v_acc & 12'hFFF);
    chk({req, " pix_byte_off"}, pix_byte_off, (xi * e_bpp) & 22'h3FFFFF);
  endtask

  task automatic run_cfg(input longint sw, input longint sh, input longint sx,
                         input longint sy, input int ow, input int oh,
                         input int bpp);
    logic [11:0] old_xf, old_yf;
    int guard;
    old_xf = src_x_frac;
    old_yf = src_y_frac;
    cfg_src_w = 32'(sw); cfg_src_h = 32'(sh);
    cfg_start_x = 32'(sx); cfg_start_y = 32'(sy);
    cfg_out_w = 16'(ow); cfg_out_h = 16'(oh); cfg_bpp = 3'(bpp);
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
    chk("R4 valid low after load", step_valid, 0);
    // strobes while the division is pending
    pix_adv = 1'b1;
    tick();
    line_start = 1'b1;
    tick();
    pix_adv = 1'b0; line_start = 1'b0;
    chk("R4 x_frac held", src_x_frac, old_xf);
    chk("R4 y_frac held", src_y_frac, old_yf);
    guard = 0;
    while (!step_valid && guard < 200) begin
      tick();
      guard++;
    end
    chk("R4 valid rises", step_valid, 1);

    e_bpp = (bpp == 2) ? 2 : 4;
    if (bpp != 2 && bpp != 4) exp_warn = 1;
    e_hs = step_of(sw, ow, (bpp == 2) ? 32768 : 16384);
    e_vs = step_of(sh, oh, 61440);
    chk("R1 R3 h_step", h_step, e_hs);
    chk("R1 R2 v_step", v_step, e_vs);
    chk("R3 warn", cfg_warn, exp_warn);
    chk("R6 line_bytes", line_bytes, ((sw >> 12) * e_bpp) & 22'h3FFFFF);
    chk("R6 x_byte_off", x_byte_off, ((sx >> 12) * e_bpp) & 22'h3FFFFF);
    chk("R6 y_line_off", y_line_off, (sy >> 12) & 20'hFFFFF);
    h_acc = sx & 12'hFFF;
    v_acc = sy & 12'hFFF;
    check_pos("R5 seed");

    for (int k = 0; k < 5; k++) begin
      pix_adv = 1'b1;
      tick();
      h_acc += e_hs;
      check_pos("R7 advance");
    end
    pix_adv = 1'b0;
    tick();
    check_pos("R7 idle hold");
    line_start = 1'b1;
    tick();
    line_start = 1'b0;
    h_acc = sx & 12'hFFF;
    v_acc += e_vs;
    check_pos("R8 line start");
    for (int k = 0; k < 3; k++) begin
      pix_adv = 1'b1;
      tick();
      h_acc += e_hs;
    end
    check_pos("R7 second line");
    line_start = 1'b1;
    tick();
    pix_adv = 1'b0; line_start = 1'b0;
    h_acc = sx & 12'hFFF;
    v_acc += e_vs;
    check_pos("R9 both strobes");
  endtask

  initial begin
    rst = 1'b1; cfg_load = 1'b0; line_start = 1'b0; pix_adv = 1'b0;
    cfg_src_w = '0; cfg_src_h = '0; cfg_start_x = '0; cfg_start_y = '0;
    cfg_out_w = '0; cfg_out_h = '0; cfg_bpp = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R10 step_valid", step_valid, 0);
    chk("R10 warn", cfg_warn, 0);
    chk("R10 h_step", h_step, 0);
    chk("R10 line_bytes", line_bytes, 0);
    chk("R10 x_idx", src_x_idx, 0);
    chk("R10 pix_byte_off", pix_byte_off, 0);
    begin
      longint srcs[5] = '{32'h0000_1000, 32'h0000_3800, 32'h0001_0000,
                          32'h000C_8000, 32'h0000_0800};
      int outs[5] = '{1, 2, 3, 5, 8};
      int bpps[3] = '{2, 4, 3};
      for (int b = 0; b < 3; b++)
        for (int s = 0; s < 5; s++)
          for (int o = 0; o < 5; o++)
            run_cfg(srcs[s], srcs[s] * 2 + 32'h300, 32'h2A80 + s * 32'h1111,
                    32'h1C40 + o * 32'h0A05, outs[o], outs[(o + s) % 5] + 1,
                    bpps[b]);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule